// File: doc/BRIEF.md
# Prioritized Interrupt State Vector Register

This block sits between the condition logic of a serial multiplex-bus data link controller and the CPU. Eight interrupt conditions come in as single-cycle set pulses. Each condition is held in its own sticky pending flag. The block continuously shows the highest-priority pending condition as a 4-bit index inside an 8-bit read-only vector. Because the index sits two bits up, the vector value is the index times four. An interrupt handler can add that value straight to the base of a jump table, so no software copy of the controller state is needed.

Clearing depends on the kind of source. Ordinary sources clear as soon as the vector is read. The two receive sources are cleared by a vector read followed by a data-register read. The transmit source is cleared by a vector read followed by a data-register write, or at any time by the transmit-end-of-data control bit. A vector read arms the second step only for the source that the read returned.

Top module: `irq_vector_reg`

## Requirements
- R1: `vec_o` is 8 bits. Bits 7, 6, 1 and 0 are always 0, and the source index sits in bits 5:2, so the vector value is the index times 4.
- R2: While reset is applied and after it is released, `vec_o` is 0x00 and `irq_o` is 0.
- R3: Bit k of `set_i` is source index k+1. The indices are:
  - 1: end of frame received
  - 2: in-frame-response byte received
  - 3: receive data full
  - 4: transmit data empty
  - 5: arbitration lost
  - 6: CRC error
  - 7: invalid symbol
  - 8: wakeup
  - 0: nothing pending
- R4: When more than one source is pending, the index shows the highest pending source number. Index 8 is the highest priority and index 1 the lowest.
- R5: A `vec_rd_i` pulse clears the source it reports when that source is index 1, 5, 6, 7 or 8.
- R6: A `vec_rd_i` pulse that reports index 2 or 3 leaves the source pending. A later `data_rd_i` pulse then clears it.
- R7: A `data_rd_i` or `data_wr_i` pulse with no matching armed source changes nothing.
- R8: The arm is held only for the source that the most recent vector read returned.
  - A vector read that returns an ordinary source, or 0, drops the arm.
  - A vector read that returns the same data source again re-arms it.
- R9: Index 4 is cleared by a `vec_rd_i` that reports it followed by a `data_wr_i`. A `teod_i` pulse clears it with or without a prior read. A `data_rd_i` does not clear it.
- R10: A set pulse in the same cycle as that source's clear leaves the source pending.
- R11: `irq_o` is 1 exactly when the index is nonzero. After a clear, the vector moves on the next clock edge to the next-highest pending source, or to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 8 | Set pulses; bit k is source index k+1 |
| vec_rd_i | input | 1 | Read strobe for the vector register |
| data_rd_i | input | 1 | Read strobe for the data register |
| data_wr_i | input | 1 | Write strobe for the data register |
| teod_i | input | 1 | Transmit-end-of-data control bit set pulse |
| vec_o | output | 8 | Vector register value |
| irq_o | output | 1 | Interrupt request, high when the index is nonzero |

## Verification
The assertions check the following on every cycle:
- the reserved bits stay zero and `irq_o` matches the index;
- with no read, data access or end-of-data pulse, the index never falls;
- a vector read of an ordinary source makes the vector change on the next edge;
- a vector read of a data source, with no other access in that cycle, never lowers the index;
- a set pulse lifts the index to at least that source.

Only the bench scenarios can show the sequenced behaviour:
- the two-step clears;
- an arm dropped by an intervening read of another source;
- data accesses with no arm;
- the set-over-clear collision;
- the full descent through all eight indices.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    SRC_NONE = 4'd0,
    SRC_EOF  = 4'd1,
    SRC_IFR  = 4'd2,
    SRC_RXF  = 4'd3,
    SRC_TXE  = 4'd4,
    SRC_ARB  = 4'd5,
    SRC_CRC  = 4'd6,
    SRC_SYM  = 4'd7,
    SRC_WAKE = 4'd8
  } src_idx_e;

  function automatic logic is_rx_src(input logic [IDX_W-1:0] idx);
    return (idx == SRC_IFR) || (idx == SRC_RXF);
  endfunction

  function automatic logic is_data_src(input logic [IDX_W-1:0] idx);
    return is_rx_src(idx) || (idx == SRC_TXE);
  endfunction
endpackage

// File: rtl/irq_src_flag.sv
module irq_src_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // set dominates so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [IDX_W-1:0]   idx_o
);
  // later (higher) sources overwrite lower ones
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (pend_i[k]) idx_o = IDX_W'(k + 1);
    end
  end
endmodule

// File: rtl/irq_clr_seq.sv
module irq_clr_seq
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               vec_rd_i,
  input  logic               data_rd_i,
  input  logic               data_wr_i,
  input  logic               teod_i,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [IDX_W-1:0] arm_q, arm_d;
  logic             rx_done, tx_done;

  assign rx_done = data_rd_i && is_rx_src(arm_q);
  assign tx_done = (data_wr_i && (arm_q == SRC_TXE)) || teod_i;

  always_comb begin
    clr_o = '0;
    if (vec_rd_i && (idx_i != SRC_NONE) && !is_data_src(idx_i))
      clr_o[int'(idx_i) - 1] = 1'b1;
    if (rx_done)
      clr_o[int'(arm_q) - 1] = 1'b1;
    if (tx_done)
      clr_o[int'(SRC_TXE) - 1] = 1'b1;
  end

  // a fresh vector read always replaces the arm
  always_comb begin
    arm_d = arm_q;
    if (vec_rd_i)
      arm_d = is_data_src(idx_i) ? idx_i : SRC_NONE;
    else if (rx_done || (tx_done && arm_q == SRC_TXE))
      arm_d = SRC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= SRC_NONE;
    else         arm_q <= arm_d;
  end
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned REG_W   = 8,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               vec_rd_i,
  input  logic               data_rd_i,
  input  logic               data_wr_i,
  input  logic               teod_i,
  output logic [REG_W-1:0]   vec_o,
  output logic               irq_o
);
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [NUM_SRC-1:0] pend, clr;
  logic [IDX_W-1:0]   idx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i[g]),
      .clr_i  (clr[g]),
      .pend_o (pend[g])
    );
  end

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .pend_i (pend),
    .idx_o  (idx)
  );

  irq_clr_seq #(.NUM_SRC(NUM_SRC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx),
    .vec_rd_i  (vec_rd_i),
    .data_rd_i (data_rd_i),
    .data_wr_i (data_wr_i),
    .teod_i    (teod_i),
    .clr_o     (clr)
  );

  always_comb begin
    vec_o = '0;
    vec_o[IDX_MSB:IDX_LSB] = idx;
  end

  assign irq_o = |pend;
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned REG_W   = 8,
  parameter int unsigned IDX_LSB = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] set_i,
  input logic               vec_rd_i,
  input logic               data_rd_i,
  input logic               data_wr_i,
  input logic               teod_i,
  input logic [REG_W-1:0]   vec_o,
  input logic               irq_o
);
  logic [IDX_W-1:0] cur_idx, set_top;
  logic             cur_ordinary, cur_set, no_access;
  logic [REG_W-1:0] rsv_mask;

  assign cur_idx = vec_o[IDX_LSB +: IDX_W];

  always_comb begin
    rsv_mask = '1;
    rsv_mask[IDX_LSB +: IDX_W] = '0;
    set_top = '0;
    for (int k = 0; k < NUM_SRC; k++) if (set_i[k]) set_top = IDX_W'(k + 1);
    cur_set = (cur_idx != 0) && set_i[int'(cur_idx) - 1];
  end

  assign cur_ordinary = (cur_idx != SRC_NONE) && !is_data_src(cur_idx);
  assign no_access    = !data_rd_i && !data_wr_i && !teod_i;

  AST_RSV_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o & rsv_mask) == '0);  // R1

  AST_IRQ_MATCHES_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (cur_idx != 0));  // R11

  AST_ORDINARY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_i && cur_ordinary && !cur_set |=> vec_o != $past(vec_o));  // R5

  AST_DATA_SRC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_i && is_data_src(cur_idx) && no_access |=> cur_idx >= $past(cur_idx));  // R6

  AST_NO_ACCESS_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_rd_i && no_access |=> cur_idx >= $past(cur_idx));  // R4

  AST_SET_REACHES_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> cur_idx >= $past(set_top));  // R10
endmodule

bind irq_vector_reg irq_vector_chk #(
  .NUM_SRC (NUM_SRC),
  .REG_W   (REG_W),
  .IDX_LSB (IDX_LSB)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .set_i     (set_i),
  .vec_rd_i  (vec_rd_i),
  .data_rd_i (data_rd_i),
  .data_wr_i (data_wr_i),
  .teod_i    (teod_i),
  .vec_o     (vec_o),
  .irq_o     (irq_o)
);

// File: tb/tb_irq_vector_reg.sv
module tb_irq_vector_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] set_i = '0;
  logic       vec_rd_i = 1'b0, data_rd_i = 1'b0, data_wr_i = 1'b0, teod_i = 1'b0;
  logic [7:0] vec_o;
  logic       irq_o;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  irq_vector_reg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .vec_rd_i(vec_rd_i),
    .data_rd_i(data_rd_i), .data_wr_i(data_wr_i), .teod_i(teod_i),
    .vec_o(vec_o), .irq_o(irq_o)
  );

  task automatic check(input logic [7:0] exp, input string tag);
    n_tests++;
    if (vec_o !== exp || irq_o !== (exp != 0)) begin
      n_fail++;
      $display("FAIL %s: vec=%02h irq=%0b expected vec=%02h irq=%0b",
               tag, vec_o, irq_o, exp, exp != 0);
    end
  endtask

  // driver: one cycle of strobes, expected vector after that edge
  task automatic cyc(input logic [7:0] s, input logic vr, input logic dr,
                     input logic dw, input logic te, input logic [7:0] exp,
                     input string tag);
    @(negedge clk_i);
    set_i = s; vec_rd_i = vr; data_rd_i = dr; data_wr_i = dw; teod_i = te;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk_i);
    #1;
    set_i = '0; vec_rd_i = 0; data_rd_i = 0; data_wr_i = 0; teod_i = 0;
  endtask

  // monitor
  initial forever begin
    @(posedge clk_i);
    #2;
    if (exp_q.size() != 0) check(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(8'h00, "R2 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(8'h00, "R2 after reset");

    cyc(8'h01, 0, 0, 0, 0, 8'h04, "R3 eof set");
    cyc(8'h80, 0, 0, 0, 0, 8'h20, "R4 wakeup over eof");
    cyc(8'h00, 1, 0, 0, 0, 8'h04, "R5 wakeup cleared by read");
    cyc(8'h04, 0, 0, 0, 0, 8'h0C, "R3 rx full set");
    cyc(8'h00, 1, 0, 0, 0, 8'h0C, "R6 rx full held on read");
    cyc(8'h00, 0, 1, 0, 0, 8'h04, "R6 rx full cleared by data read");
    cyc(8'h02, 0, 0, 0, 0, 8'h08, "R3 ifr set");
    cyc(8'h00, 0, 1, 0, 0, 8'h08, "R7 data read unarmed");
    cyc(8'h00, 1, 0, 0, 0, 8'h08, "R6 ifr held");
    cyc(8'h00, 1, 0, 0, 0, 8'h08, "R8 ifr re-read");
    cyc(8'h00, 0, 1, 0, 0, 8'h04, "R8 re-armed ifr cleared");
    cyc(8'h04, 0, 0, 0, 0, 8'h0C, "R3 rx full set again");
    cyc(8'h00, 1, 0, 0, 0, 8'h0C, "R6 arm rx full");
    cyc(8'h10, 0, 0, 0, 0, 8'h14, "R4 arbitration over rx full");
    cyc(8'h00, 1, 0, 0, 0, 8'h0C, "R5 arbitration cleared");
    cyc(8'h00, 0, 1, 0, 0, 8'h0C, "R8 arm dropped");
    cyc(8'h00, 1, 0, 0, 0, 8'h0C, "R6 rx full rearm");
    cyc(8'h00, 0, 1, 0, 0, 8'h04, "R6 rx full cleared");
    cyc(8'h08, 0, 0, 0, 0, 8'h10, "R3 tx empty set");
    cyc(8'h00, 0, 1, 0, 0, 8'h10, "R7 data read unarmed tx");
    cyc(8'h00, 0, 0, 1, 0, 8'h10, "R7 data write unarmed");
    cyc(8'h00, 1, 0, 0, 0, 8'h10, "R9 tx empty held on read");
    cyc(8'h00, 0, 1, 0, 0, 8'h10, "R9 data read does not clear tx");
    cyc(8'h00, 0, 0, 1, 0, 8'h04, "R9 data write clears tx");
    cyc(8'h08, 0, 0, 0, 0, 8'h10, "R9 tx empty set again");
    cyc(8'h00, 0, 0, 0, 1, 8'h04, "R9 teod clears tx");
    cyc(8'h01, 1, 0, 0, 0, 8'h04, "R10 set beats clear");
    cyc(8'h00, 1, 0, 0, 0, 8'h00, "R11 last source cleared");
    cyc(8'h60, 0, 0, 0, 0, 8'h1C, "R4 symbol over crc");
    cyc(8'h00, 1, 0, 0, 0, 8'h18, "R11 next highest crc");
    cyc(8'h00, 1, 0, 0, 0, 8'h00, "R5 crc cleared");
    cyc(8'h00, 1, 0, 0, 0, 8'h00, "R8 empty read");
    cyc(8'hFF, 0, 0, 0, 0, 8'h20, "R1 all set");
    cyc(8'h00, 1, 0, 0, 0, 8'h1C, "R3 index 7");
    cyc(8'h00, 1, 0, 0, 0, 8'h18, "R3 index 6");
    cyc(8'h00, 1, 0, 0, 0, 8'h14, "R3 index 5");
    cyc(8'h00, 1, 0, 0, 0, 8'h10, "R3 index 4");
    cyc(8'h00, 1, 0, 0, 0, 8'h10, "R9 index 4 held");
    cyc(8'h00, 0, 0, 0, 1, 8'h0C, "R9 teod then index 3");
    cyc(8'h00, 1, 0, 0, 0, 8'h0C, "R6 index 3 held");
    cyc(8'h00, 0, 1, 0, 0, 8'h08, "R3 index 2");
    cyc(8'h00, 1, 0, 0, 0, 8'h08, "R6 index 2 held");
    cyc(8'h00, 0, 1, 0, 0, 8'h04, "R3 index 1");
    cyc(8'h00, 1, 0, 0, 0, 8'h00, "R2 back to empty");
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule